// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block sits between the oscillator input of a small microcontroller and the rest of the chip. It halves the raw oscillator rate into a clock-enable tick and turns that tick into two gated enables: one for the CPU and one for the peripherals (RAM, timers, serial port, interrupt logic). A power-mode state machine selects full run, idle (CPU held, peripherals running) or power-down (oscillator stopped, all functions halted, RAM kept).

The external reset pin is handled on two paths. An asynchronous path drives the port pads to their reset state at once, whether or not the oscillator runs. A qualified path passes the pin through a two-flop synchronizer and a hold counter, and the core is reset only after the pin has been seen high for two full machine cycles (24 oscillator periods). When any code-protection lock bit is set, the level of the external-access strap is captured while the core reset is active and that captured value is presented afterward; with no lock bit set the strap level passes straight through.

The controller's own registers run on the oscillator clock and are cleared by an active-low power-on reset. The oscillator-run enable is rebuilt from the reset pin without a clock so that a reset can restart a stopped oscillator.

Top module: `clk_pwr_ctl`

## Requirements
- R1: `per_clk_en` is high in exactly every second oscillator period (never two periods in a row) while not in power-down; in run mode `cpu_clk_en` pulses at the same rate.
- R2: With `rst_pin` raised just after a rising edge of `osc_clk`, `core_rst` is still low after the 25th following rising edge and high after the 26th (two synchronizer stages plus 24 counted periods).
- R3: A high level on `rst_pin` that lasts 23 oscillator rising edges and is followed by a low level never raises `core_rst`; any low synchronized sample clears the hold count.
- R4: After `rst_pin` falls, `core_rst` stays high through the next two rising edges and is low after the third.
- R5: `port_rst` equals `rst_pin` with no clock edge in between, also during power-down.
- R6: In idle mode `cpu_clk_en` stays low while `per_clk_en` keeps pulsing every second period.
- R7: In power-down `cpu_clk_en`, `per_clk_en` and `osc_run_en` are all low; `osc_run_en` rises with no clock edge as soon as `rst_pin` is high.
- R8: `wake_irq` returns idle mode to run at the next edge and is ignored in power-down; an active `core_rst` returns both idle and power-down to run.
- R9: When `idle_req` and `pdown_req` are taken in the same edge in run mode, power-down wins.
- R10: With `lock_bits` non-zero, `ext_acc_q` shows the `ext_acc_pin` level sampled at the last rising edge at which `core_rst` was high, regardless of later pin changes; with `lock_bits` equal to zero, `ext_acc_q` follows `ext_acc_pin` without a clock edge.
- R11: After power-on reset and with `rst_pin` low, the block is in run mode: `core_rst` low, `port_rst` low, `osc_run_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Active-low power-on reset of the controller registers |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| ext_acc_pin | input | 1 | External-access strap level |
| lock_bits | input | 2 | Code-protection lock bits, any bit set enables strap capture |
| idle_req | input | 1 | Request to enter idle mode |
| pdown_req | input | 1 | Request to enter power-down mode |
| wake_irq | input | 1 | Enabled interrupt pending, ends idle |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run_en | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Qualified synchronous core reset |
| port_rst | output | 1 | Asynchronous port reset |
| ext_acc_q | output | 1 | External-access value presented to the fetch logic |

## Verification
The qualified reset and the mode machine meet in one edge: the bench puts the block into power-down, sends a wake interrupt that must be ignored, then raises the reset pin while still in power-down and judges that the oscillator enable returns at once, that the core reset rises only after the full hold, and that the first edge with the core reset high returns the mode to run. The same coincidence with the strap capture is provoked by holding the strap level through the release of the reset and then changing it, judging that the locked output keeps the level of the last reset edge while the unlocked output follows the pin. Idle and power-down requests are also raised on the same edge to judge priority.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;

  // Saturating hold count: any low sample restarts the count.
  function automatic int unsigned hold_next(int unsigned cnt, logic hi, int unsigned lim);
    if (!hi) return 0;
    if (cnt >= lim) return lim;
    return cnt + 1;
  endfunction

  // Mode transition: core reset first, then power-down over idle.
  function automatic pmode_e mode_next(pmode_e cur, logic rst, logic idle_r,
                                       logic pd_r, logic wake);
    if (rst) return MODE_RUN;
    case (cur)
      MODE_RUN:  begin
        if (pd_r) return MODE_PDOWN;
        if (idle_r) return MODE_IDLE;
        return MODE_RUN;
      end
      MODE_IDLE: return wake ? MODE_RUN : MODE_IDLE;
      default:   return MODE_PDOWN;
    endcase
  endfunction

endpackage

// File: rtl/cpc_divider.sv
module cpc_divider #(
  parameter int DIV = 2
) (
  input  logic osc_clk,
  input  logic por_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] ph_q;

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n)           ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                  ph_q <= ph_q + 1'b1;
  end

  assign tick = (ph_q == LAST);

  // R1: no two ticks in a row
  assert_tick_spaced_R1: assert property (@(posedge osc_clk) disable iff (!por_n)
    tick |=> !tick);

endmodule

// File: rtl/cpc_rst_qual.sv
module cpc_rst_qual
  import cpc_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int HOLD_MC    = 2
) (
  input  logic osc_clk,
  input  logic por_n,
  input  logic rst_pin,
  output logic core_rst
);
  localparam int HOLD = OSC_PER_MC * HOLD_MC;
  localparam int CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic          sync1_q, sync_hi;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) begin
      sync1_q <= 1'b0;
      sync_hi <= 1'b0;
    end else begin
      sync1_q <= rst_pin;
      sync_hi <= sync1_q;
    end
  end

  assign cnt_d = CW'(hold_next(32'(cnt_q), sync_hi, HOLD));

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign core_rst = (cnt_q == HOLD_V);

  // R3: a low synchronized sample removes the core reset at the next edge
  assert_low_clears_R3: assert property (@(posedge osc_clk) disable iff (!por_n)
    !sync_hi |=> !core_rst);

  // R2: the core reset only appears after the full hold
  assert_full_hold_R2: assert property (@(posedge osc_clk) disable iff (!por_n)
    $rose(core_rst) |-> ($past(cnt_q) == HOLD_V - 1'b1));

endmodule

// File: rtl/cpc_mode_fsm.sv
module cpc_mode_fsm
  import cpc_pkg::*;
(
  input  logic   osc_clk,
  input  logic   por_n,
  input  logic   core_rst,
  input  logic   idle_req,
  input  logic   pdown_req,
  input  logic   wake_irq,
  output pmode_e mode
);
  pmode_e mode_q;

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_next(mode_q, core_rst, idle_req, pdown_req, wake_irq);
  end

  assign mode = mode_q;

  // R8: only the core reset leaves power-down
  assert_pd_sticky_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
    (mode_q == MODE_PDOWN && !core_rst) |=> (mode_q == MODE_PDOWN));

  // R8: core reset always lands in run
  assert_rst_to_run_R8: assert property (@(posedge osc_clk) disable iff (!por_n)
    core_rst |=> (mode_q == MODE_RUN));

  // R9: simultaneous requests in run go to power-down
  assert_pd_wins_R9: assert property (@(posedge osc_clk) disable iff (!por_n)
    (mode_q == MODE_RUN && !core_rst && pdown_req && idle_req) |=> (mode_q == MODE_PDOWN));

endmodule

// File: rtl/cpc_strap_latch.sv
module cpc_strap_latch #(
  parameter int LOCK_W = 2
) (
  input  logic              osc_clk,
  input  logic              por_n,
  input  logic              core_rst,
  input  logic              strap,
  input  logic [LOCK_W-1:0] lock_bits,
  output logic              strap_out
);
  logic held_q;
  logic locked;

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n)        held_q <= 1'b0;
    else if (core_rst) held_q <= strap;
  end

  assign locked    = |lock_bits;
  assign strap_out = locked ? held_q : strap;

  // R10: with a lock set and no reset, the output does not move
  assert_strap_frozen_R10: assert property (@(posedge osc_clk) disable iff (!por_n)
    (!core_rst && locked) |=> (!(|lock_bits) || $stable(strap_out)));

endmodule

// File: rtl/clk_pwr_ctl.sv
module clk_pwr_ctl
  import cpc_pkg::*;
#(
  parameter int OSC_PER_MC = 12,
  parameter int HOLD_MC    = 2,
  parameter int CLK_DIV    = 2,
  parameter int LOCK_W     = 2
) (
  input  logic              osc_clk,
  input  logic              por_n,
  input  logic              rst_pin,
  input  logic              ext_acc_pin,
  input  logic [LOCK_W-1:0] lock_bits,
  input  logic              idle_req,
  input  logic              pdown_req,
  input  logic              wake_irq,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_run_en,
  output logic              core_rst,
  output logic              port_rst,
  output logic              ext_acc_q
);
  logic   tick;
  pmode_e mode;
  logic   in_run, in_pd;

  cpc_divider #(.DIV(CLK_DIV)) u_div (
    .osc_clk (osc_clk),
    .por_n   (por_n),
    .tick    (tick)
  );

  cpc_rst_qual #(.OSC_PER_MC(OSC_PER_MC), .HOLD_MC(HOLD_MC)) u_rq (
    .osc_clk  (osc_clk),
    .por_n    (por_n),
    .rst_pin  (rst_pin),
    .core_rst (core_rst)
  );

  cpc_mode_fsm u_fsm (
    .osc_clk   (osc_clk),
    .por_n     (por_n),
    .core_rst  (core_rst),
    .idle_req  (idle_req),
    .pdown_req (pdown_req),
    .wake_irq  (wake_irq),
    .mode      (mode)
  );

  cpc_strap_latch #(.LOCK_W(LOCK_W)) u_strap (
    .osc_clk   (osc_clk),
    .por_n     (por_n),
    .core_rst  (core_rst),
    .strap     (ext_acc_pin),
    .lock_bits (lock_bits),
    .strap_out (ext_acc_q)
  );

  assign in_run     = (mode == MODE_RUN);
  assign in_pd      = (mode == MODE_PDOWN);
  assign cpu_clk_en = tick & in_run;
  assign per_clk_en = tick & ~in_pd;
  assign osc_run_en = ~in_pd | rst_pin;
  assign port_rst   = rst_pin;

  // R7: the reset pin always restarts the oscillator
  always_comb begin
    if (rst_pin === 1'b1)
      assert_osc_restart_R7: assert (osc_run_en === 1'b1);
  end

  // R7: power-down leaves no clock enable active
  assert_pd_quiet_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
    in_pd |-> !(cpu_clk_en || per_clk_en));

  // R6: the peripheral enable keeps its rhythm through idle
  assert_idle_per_R6: assert property (@(posedge osc_clk) disable iff (!por_n)
    (mode == MODE_IDLE && !per_clk_en && $past(mode == MODE_IDLE)) |=> per_clk_en || core_rst || mode != MODE_IDLE);

endmodule

// File: tb/sim_clk_pwr_ctl.sv
module sim_clk_pwr_ctl;
  logic       osc_clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_pin = 1'b0;
  logic       ext_acc_pin = 1'b0;
  logic [1:0] lock_bits = 2'b00;
  logic       idle_req = 1'b0, pdown_req = 1'b0, wake_irq = 1'b0;
  logic       cpu_clk_en, per_clk_en, osc_run_en, core_rst, port_rst, ext_acc_q;

  int checks = 0;
  int errors = 0;

  always #10 osc_clk = ~osc_clk;

  clk_pwr_ctl u0 (
    .osc_clk(osc_clk), .por_n(por_n), .rst_pin(rst_pin), .ext_acc_pin(ext_acc_pin),
    .lock_bits(lock_bits), .idle_req(idle_req), .pdown_req(pdown_req), .wake_irq(wake_irq),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run_en(osc_run_en),
    .core_rst(core_rst), .port_rst(port_rst), .ext_acc_q(ext_acc_q)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge osc_clk);
  endtask

  // count enable pulses over n periods (samples at falling edges)
  task automatic count_en(input int n, output int cpu_n, output int per_n, output int back2back);
    logic prev = 1'b0;
    cpu_n = 0; per_n = 0; back2back = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge osc_clk);
      if (cpu_clk_en) cpu_n++;
      if (per_clk_en) per_n++;
      if (per_clk_en && prev) back2back++;
      prev = per_clk_en;
    end
  endtask

  task automatic full_reset();
    rst_pin = 1'b1;
    step(30);
    rst_pin = 1'b0;
    step(5);
  endtask

  task automatic t_reset_state();
    chk(core_rst == 1'b0, "R11 core_rst", int'(core_rst), 0);
    chk(port_rst == 1'b0, "R11 port_rst", int'(port_rst), 0);
    chk(osc_run_en == 1'b1, "R11 osc_run_en", int'(osc_run_en), 1);
  endtask

  task automatic t_divider();
    int c, p, b;
    count_en(20, c, p, b);
    chk(p == 10, "R1 per pulses", p, 10);
    chk(c == 10, "R1 cpu pulses", c, 10);
    chk(b == 0, "R1 back-to-back", b, 0);
  endtask

  task automatic t_rst_qualify();
    rst_pin = 1'b1;
    #1;
    chk(port_rst == 1'b1, "R5 port_rst async", int'(port_rst), 1);
    #1;
    step(25);
    chk(core_rst == 1'b0, "R2 core_rst after 25 edges", int'(core_rst), 0);
    step(1);
    chk(core_rst == 1'b1, "R2 core_rst after 26 edges", int'(core_rst), 1);
    step(4);
    rst_pin = 1'b0;
    #1;
    chk(port_rst == 1'b0, "R5 port_rst release", int'(port_rst), 0);
    step(2);
    chk(core_rst == 1'b1, "R4 held two edges", int'(core_rst), 1);
    step(1);
    chk(core_rst == 1'b0, "R4 released third edge", int'(core_rst), 0);
  endtask

  task automatic t_rst_glitch();
    int seen = 0;
    for (int round = 0; round < 2; round++) begin
      rst_pin = 1'b1;
      for (int i = 0; i < 23; i++) begin
        @(negedge osc_clk);
        if (core_rst) seen++;
      end
      rst_pin = 1'b0;
      for (int i = 0; i < 3; i++) begin
        @(negedge osc_clk);
        if (core_rst) seen++;
      end
    end
    chk(seen == 0, "R3 short highs never reset", seen, 0);
  endtask

  task automatic t_idle();
    int c, p, b;
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    count_en(10, c, p, b);
    chk(c == 0, "R6 cpu stopped in idle", c, 0);
    chk(p == 5, "R6 per running in idle", p, 5);
    wake_irq = 1'b1; step(1); wake_irq = 1'b0;
    count_en(10, c, p, b);
    chk(c == 5, "R8 wake returns to run", c, 5);
  endtask

  task automatic t_pdown();
    int c, p, b;
    pdown_req = 1'b1; step(1); pdown_req = 1'b0;
    count_en(10, c, p, b);
    chk(c + p == 0, "R7 enables off in power-down", c + p, 0);
    chk(osc_run_en == 1'b0, "R7 oscillator stopped", int'(osc_run_en), 0);
    wake_irq = 1'b1; step(1); wake_irq = 1'b0;
    step(2);
    chk(osc_run_en == 1'b0, "R8 wake ignored in power-down", int'(osc_run_en), 0);
    rst_pin = 1'b1;
    #1;
    chk(osc_run_en == 1'b1, "R7 reset restarts oscillator", int'(osc_run_en), 1);
    chk(port_rst == 1'b1, "R5 port_rst in power-down", int'(port_rst), 1);
    #1;
    step(25);
    chk(core_rst == 1'b0, "R2 hold counted in power-down", int'(core_rst), 0);
    step(1);
    chk(core_rst == 1'b1, "R2 core_rst from power-down", int'(core_rst), 1);
    rst_pin = 1'b0;
    step(5);
    count_en(10, c, p, b);
    chk(c == 5, "R8 reset exits power-down", c, 5);
  endtask

  task automatic t_priority();
    int c, p, b;
    idle_req = 1'b1; pdown_req = 1'b1; step(1);
    idle_req = 1'b0; pdown_req = 1'b0;
    count_en(6, c, p, b);
    chk(p == 0, "R9 power-down wins per", p, 0);
    chk(osc_run_en == 1'b0, "R9 power-down wins osc", int'(osc_run_en), 0);
    full_reset();
    idle_req = 1'b1; step(1); idle_req = 1'b0;
    full_reset();
    count_en(10, c, p, b);
    chk(c == 5, "R8 reset exits idle", c, 5);
  endtask

  task automatic t_strap();
    lock_bits = 2'b01; ext_acc_pin = 1'b1;
    full_reset();
    ext_acc_pin = 1'b0;
    step(3);
    chk(ext_acc_q == 1'b1, "R10 locked keeps captured 1", int'(ext_acc_q), 1);
    lock_bits = 2'b00;
    #1;
    chk(ext_acc_q == 1'b0, "R10 unlocked follows pin 0", int'(ext_acc_q), 0);
    ext_acc_pin = 1'b1;
    #1;
    chk(ext_acc_q == 1'b1, "R10 unlocked follows pin 1", int'(ext_acc_q), 1);
    lock_bits = 2'b10; ext_acc_pin = 1'b0;
    step(3);
    chk(ext_acc_q == 1'b1, "R10 other lock bit keeps capture", int'(ext_acc_q), 1);
    full_reset();
    ext_acc_pin = 1'b1;
    step(3);
    chk(ext_acc_q == 1'b0, "R10 recapture 0 at reset", int'(ext_acc_q), 0);
    lock_bits = 2'b00;
  endtask

  initial begin
    step(3);
    por_n = 1'b1;
    step(3);
    t_reset_state();
    t_divider();
    t_rst_qualify();
    step(3);
    t_rst_glitch();
    step(3);
    t_idle();
    t_pdown();
    t_priority();
    t_strap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule